// File: doc/BRIEF.md
# Single-Wire Slave Bit and Slot Engine

This block is the bit layer of a slave on a single-wire, open-drain bus. It takes an already synchronised, oversampled copy of the bus line and drives one output: an enable for the pull-down transistor. Each falling edge from the master opens a time slot. For a write slot, the engine samples the line a fixed delay later to decide the bit. For a read slot, it holds the line low to send a zero. A long low is taken as a bus reset, and the engine answers it with a presence pulse.

Two speeds are supported: standard and overdrive. The layer above raises a one-cycle flag to enter overdrive. The length of each reset low decides whether overdrive survives that reset. Rising edges pass through a glitch filter, which plays the role of switching hysteresis. All timing constants are parameters counted in clock cycles.

Toward the layer above, the engine offers:
- received bytes, least significant bit first, with a one-cycle valid strobe;
- a per-bit request strobe, used to present the next transmit bit;
- a one-cycle reset event;
- the number of bits received between the previous reset and this one.

Top module: `onewire_slot_engine`

## Requirements
- R1: While rst_n is low, pull_o, od_o, rx_valid_o, tx_req_o and reset_o are all 0.
- R2: A falling edge of the filtered line opens a slot. The bit is 1 if the filtered line is high at the sample delay (S_SAMPLE cycles at standard speed, O_SAMPLE in overdrive) after the edge, and 0 otherwise. Bits fill a byte least significant bit first. After every eighth bit, rx_byte_o carries the byte while rx_valid_o is high for exactly one cycle.
- R3: If tx_en_i = 1 and tx_bit_i = 0 at the falling edge, pull_o rises in the next cycle. It stays high through the hold window (S_HOLD or O_HOLD cycles), so the master reads 0 at its own sample point. With tx_bit_i = 1 or tx_en_i = 0, the line is not driven during the slot.
- R4: A low lasting at least S_RST cycles (O_RST in overdrive) and ending with a filtered rising edge produces a one-cycle reset_o pulse, and that low is not counted as a data bit. A shorter low is a data bit.
- R5: After a reset, the engine waits the presence delay (S_PDH or O_PDH cycles, plus the filter delay). It then holds pull_o high for exactly S_PDL or O_PDL cycles, using the speed that is in force after that reset.
- R6: od_set_i = 1 sets od_o to 1. A reset whose low lasts at least OD_DROP cycles clears od_o. A shorter reset leaves od_o unchanged.
- R7: At each reset, rst_bits_o takes the number of bits completed since the previous reset. Any partial byte is discarded, and the next bit becomes bit 0 of a new byte.
- R8: A high interval shorter than GLITCH cycles inside a low period is ignored: it neither ends a slot nor ends a reset.
- R9: tx_req_o is high for one cycle for each completed bit. It is always high in the cycle that rx_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Synchronised bus line level |
| od_set_i | input | 1 | One-cycle request to enter overdrive speed |
| tx_en_i | input | 1 | The next slot is a read slot driven by this slave |
| tx_bit_i | input | 1 | Bit to send in the next read slot |
| pull_o | output | 1 | Pull-down enable for the open-drain line |
| od_o | output | 1 | Current speed, 1 = overdrive |
| rx_byte_o | output | 8 | Last completed byte, LSB received first |
| rx_valid_o | output | 1 | One-cycle strobe for rx_byte_o |
| tx_req_o | output | 1 | One-cycle strobe per completed bit |
| reset_o | output | 1 | One-cycle bus reset event |
| rst_bits_o | output | BITS_W | Bits completed between the last two resets |

## Verification
The assertions rely on certain input conditions:
- tx_en_i and tx_bit_i are stable in the cycle of a master falling edge.
- od_set_i is pulsed only while the bus is idle.
- The master leaves the line high long enough after each slot for the filter to settle before the next edge.

The stimulus keeps to these conditions. Every master low is chosen well inside its class: write-one and read lows end before the sample delay, write-zero lows stay below the reset threshold, and reset lows are either just above the overdrive threshold or beyond the drop limit. Injected glitches are always shorter than the filter length.

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine #(
  parameter int S_SAMPLE = 120,
  parameter int S_HOLD   = 120,
  parameter int S_RST    = 480,
  parameter int S_PDH    = 120,
  parameter int S_PDL    = 480,
  parameter int O_SAMPLE = 12,
  parameter int O_HOLD   = 12,
  parameter int O_RST    = 64,
  parameter int O_PDH    = 12,
  parameter int O_PDL    = 48,
  parameter int OD_DROP  = 1920,
  parameter int GLITCH   = 3,
  parameter int BITS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              od_set_i,
  input  logic              tx_en_i,
  input  logic              tx_bit_i,
  output logic              pull_o,
  output logic              od_o,
  output logic [7:0]        rx_byte_o,
  output logic              rx_valid_o,
  output logic              tx_req_o,
  output logic              reset_o,
  output logic [BITS_W-1:0] rst_bits_o
);

  localparam int CW = $clog2(S_RST + S_PDL + S_PDH + S_SAMPLE + S_HOLD + 2);
  localparam int LW = $clog2(OD_DROP + 2) + 1;
  localparam int GW = $clog2(GLITCH + 1);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_SLOT = 3'd1;
  localparam logic [2:0] ST_WAIT = 3'd2;
  localparam logic [2:0] ST_PDH  = 3'd3;
  localparam logic [2:0] ST_PDL  = 3'd4;
  localparam logic [2:0] ST_REC  = 3'd5;

  logic [2:0]        state;
  logic [CW-1:0]     cnt;
  logic [LW-1:0]     lowcnt;
  logic [GW-1:0]     hicnt;
  logic              filt;
  logic              drv0;
  logic [6:0]        sreg;
  logic [2:0]        bidx;
  logic [BITS_W-1:0] bitcnt;

  wire filt_nx = line_i & (filt | (hicnt == GW'(GLITCH - 1)));
  wire fall    = filt & ~line_i;
  wire rise    = ~filt & filt_nx;

  wire [CW-1:0] t_sample = od_o ? CW'(O_SAMPLE) : CW'(S_SAMPLE);
  wire [CW-1:0] t_hold   = od_o ? CW'(O_HOLD)   : CW'(S_HOLD);
  wire [CW-1:0] t_pdh    = od_o ? CW'(O_PDH)    : CW'(S_PDH);
  wire [CW-1:0] t_pdl    = od_o ? CW'(O_PDL)    : CW'(S_PDL);
  wire [LW-1:0] t_rst    = od_o ? LW'(O_RST)    : LW'(S_RST);

  wire is_reset = rise & (lowcnt >= t_rst);
  wire commit   = ~is_reset & (((state == ST_SLOT) & (cnt == t_sample) & filt) |
                               ((state == ST_WAIT) & rise));
  wire cbit     = (state == ST_SLOT);

  assign pull_o = (state == ST_PDL) | ((state == ST_SLOT) & drv0 & (cnt <= t_hold));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      lowcnt     <= '0;
      hicnt      <= '0;
      filt       <= 1'b0;
      drv0       <= 1'b0;
      sreg       <= '0;
      bidx       <= '0;
      bitcnt     <= '0;
      od_o       <= 1'b0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      tx_req_o   <= 1'b0;
      reset_o    <= 1'b0;
      rst_bits_o <= '0;
    end else begin
      filt       <= filt_nx;
      hicnt      <= (line_i & ~filt & ~filt_nx) ? GW'(hicnt + GW'(1)) : '0;
      rx_valid_o <= 1'b0;
      tx_req_o   <= 1'b0;
      reset_o    <= 1'b0;

      if (filt_nx | pull_o)   lowcnt <= '0;
      else if (lowcnt != '1)  lowcnt <= lowcnt + LW'(1);

      if (od_set_i) od_o <= 1'b1;

      if (commit) begin
        sreg     <= {cbit, sreg[6:1]};
        bidx     <= bidx + 3'd1;
        tx_req_o <= 1'b1;
        if (bitcnt != '1) bitcnt <= bitcnt + BITS_W'(1);
        if (bidx == 3'd7) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {cbit, sreg};
        end
      end

      if (is_reset) begin
        reset_o    <= 1'b1;
        rst_bits_o <= bitcnt;
        bitcnt     <= '0;
        bidx       <= '0;
        if (lowcnt >= LW'(OD_DROP)) od_o <= 1'b0;
        state      <= ST_PDH;
        cnt        <= '0;
      end else begin
        case (state)
          ST_IDLE: if (fall) begin
            state <= ST_SLOT;
            cnt   <= '0;
            drv0  <= tx_en_i & ~tx_bit_i;
          end
          ST_SLOT: begin
            cnt <= cnt + CW'(1);
            if (cnt == t_sample) state <= filt ? ST_IDLE : ST_WAIT;
          end
          ST_WAIT: if (rise) state <= ST_IDLE;
          ST_PDH: begin
            cnt <= cnt + CW'(1);
            if (cnt == t_pdh - CW'(1)) begin
              state <= ST_PDL;
              cnt   <= '0;
            end
          end
          ST_PDL: begin
            cnt <= cnt + CW'(1);
            if (cnt == t_pdl - CW'(1)) state <= ST_REC;
          end
          ST_REC:  if (filt) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/onewire_slot_engine_chk.sv
module onewire_slot_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       od_set_i,
  input logic       tx_en_i,
  input logic       tx_bit_i,
  input logic       pull_o,
  input logic       od_o,
  input logic       rx_valid_o,
  input logic       tx_req_o,
  input logic       reset_o,
  input logic [2:0] state
);

  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r4_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o |=> !reset_o);

  a_r3_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_o && !$past(pull_o)) |-> ($past(tx_en_i && !tx_bit_i) || $past(state) == 3'd3));

  a_r5_pdl_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && $past(state) != 3'd4) |-> ($past(state) == 3'd3));

  a_r6_od_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(od_o) |-> ($past(od_set_i) || reset_o));

  a_r9_req_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> tx_req_o);

endmodule

bind onewire_slot_engine onewire_slot_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .od_set_i   (od_set_i),
  .tx_en_i    (tx_en_i),
  .tx_bit_i   (tx_bit_i),
  .pull_o     (pull_o),
  .od_o       (od_o),
  .rx_valid_o (rx_valid_o),
  .tx_req_o   (tx_req_o),
  .reset_o    (reset_o),
  .state      (state)
);

// File: tb/onewire_slot_engine_tb.sv
module onewire_slot_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mlow = 1'b0;
  logic glitch_hi = 1'b0;
  logic od_set = 1'b0;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b0;
  logic pull, od, rx_valid, tx_req, rst_ev;
  logic [7:0] rx_byte;
  logic [15:0] rst_bits;
  wire line = glitch_hi | ~(mlow | pull);

  localparam int GLITCH = 3;

  onewire_slot_engine u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .od_set_i(od_set),
    .tx_en_i(tx_en), .tx_bit_i(tx_bit), .pull_o(pull), .od_o(od),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .tx_req_o(tx_req),
    .reset_o(rst_ev), .rst_bits_o(rst_bits)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, nrst = 0, ngot = 0, nreq = 0, nbits = 0;
  logic [7:0] got [0:255];
  bit done = 0;
  bit spd = 0;

  always @(negedge clk) if (rst_n) begin
    if (rst_ev) nrst++;
    if (tx_req) nreq++;
    if (rx_valid) begin
      if (ngot < 256) got[ngot] = rx_byte;
      ngot++;
    end
  end

  function automatic int f_w1(bit o);    return o ? 6 : 40;    endfunction
  function automatic int f_w0(bit o);    return o ? 40 : 320;  endfunction
  function automatic int f_slot(bit o);  return o ? 56 : 360;  endfunction
  function automatic int f_smp(bit o);   return o ? 12 : 120;  endfunction
  function automatic int f_rdlow(bit o); return o ? 3 : 20;    endfunction
  function automatic int f_msamp(bit o); return o ? 8 : 60;    endfunction
  function automatic int f_pdh(bit o);   return o ? 12 : 120;  endfunction
  function automatic int f_pdl(bit o);   return o ? 48 : 480;  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_bit(bit b, bit glitch);
    int lowlen = b ? f_w1(spd) : f_w0(spd);
    mlow = 1;
    if (glitch && !b) begin
      cyc(f_smp(spd));
      glitch_hi = 1;
      cyc(2);
      glitch_hi = 0;
      cyc(lowlen - f_smp(spd) - 2);
    end else cyc(lowlen);
    mlow = 0;
    cyc(f_slot(spd) - lowlen);
    nbits++;
  endtask

  task automatic wr_byte(logic [7:0] v, bit glitch, string req);
    int k0 = ngot;
    for (int i = 0; i < 8; i++) wr_bit(v[i], glitch);
    chk(ngot == k0 + 1 && got[k0] == v, req, (ngot > k0) ? int'(got[k0]) : -1, int'(v));
  endtask

  task automatic rd_byte(logic [7:0] v);
    int k0 = ngot;
    int r0 = nreq;
    for (int i = 0; i < 8; i++) begin
      tx_bit = v[i];
      tx_en = 1;
      mlow = 1;
      cyc(f_rdlow(spd));
      mlow = 0;
      cyc(f_msamp(spd) - f_rdlow(spd));
      chk(line == v[i], "R3 line level at master sample", int'(line), int'(v[i]));
      cyc(f_slot(spd) - f_msamp(spd));
      tx_en = 0;
      nbits++;
    end
    chk(ngot == k0 + 1 && got[k0] == v, "R2 byte seen during read", (ngot > k0) ? int'(got[k0]) : -1, int'(v));
    chk(nreq == r0 + 8, "R9 one request per bit", nreq - r0, 8);
  endtask

  task automatic bus_reset(int len, bit glitch, bit exp_od);
    int r0 = nrst;
    int ebits = nbits;
    int gap = 0;
    int wid = 0;
    mlow = 1;
    if (glitch) begin
      cyc(len / 2);
      glitch_hi = 1;
      cyc(2);
      glitch_hi = 0;
      cyc(len - len / 2 - 2);
    end else cyc(len);
    mlow = 0;
    while (!pull && gap < 5000) begin cyc(1); gap++; end
    while (pull && wid < 5000) begin cyc(1); wid++; end
    spd = exp_od;
    nbits = 0;
    chk(nrst == r0 + 1, "R4 reset event (R8 if glitched)", nrst - r0, 1);
    chk(od == exp_od, "R6 speed after reset", int'(od), int'(exp_od));
    chk(int'(rst_bits) == ebits, "R7 bit count at reset", int'(rst_bits), ebits);
    chk(gap >= f_pdh(exp_od) && gap <= f_pdh(exp_od) + GLITCH + 4, "R5 presence delay", gap, f_pdh(exp_od));
    chk(wid == f_pdl(exp_od), "R5 presence width", wid, f_pdl(exp_od));
    cyc(20);
  endtask

  task automatic enter_od();
    od_set = 1;
    cyc(1);
    od_set = 0;
    spd = 1;
    chk(od == 1'b1, "R6 overdrive set", int'(od), 1);
  endtask

  initial begin
    logic [7:0] v;
    int r0;
    int k0;
    void'($urandom(32'd20240611));
    cyc(5);
    chk(!pull && !od && !rx_valid && !tx_req && !rst_ev, "R1 reset state", int'({pull, od, rx_valid, tx_req, rst_ev}), 0);
    rst_n = 1;
    cyc(5);
    bus_reset(2000, 0, 0);

    wr_byte(8'hA5, 0, "R2 directed byte standard");
    for (int i = 0; i < 3; i++) wr_byte(8'($urandom), 0, "R2 random byte standard");

    v = 8'($urandom);
    r0 = nrst;
    k0 = ngot;
    mlow = 1;
    cyc(400);
    mlow = 0;
    cyc(60);
    nbits++;
    chk(nrst == r0, "R4 long low below threshold is no reset", nrst - r0, 0);
    for (int i = 1; i < 8; i++) wr_bit(v[i], 0);
    chk(ngot == k0 + 1 && got[k0] == {v[7:1], 1'b0}, "R4 long low taken as bit 0",
        (ngot > k0) ? int'(got[k0]) : -1, int'({v[7:1], 1'b0}));

    wr_bit(1, 0); wr_bit(0, 0); wr_bit(1, 0);
    bus_reset(2000, 0, 0);
    wr_byte(8'h3C, 0, "R7 byte realigned after partial");
    wr_byte(8'($urandom) & 8'h6E, 1, "R8 glitch at sample point");
    rd_byte(8'($urandom));
    rd_byte(8'h5A);

    enter_od();
    for (int i = 0; i < 3; i++) wr_byte(8'($urandom), 0, "R2 random byte overdrive");
    rd_byte(8'($urandom));
    bus_reset(70, 0, 1);
    wr_byte(8'($urandom), 0, "R6 overdrive kept after short reset");
    rd_byte(8'($urandom));
    bus_reset(2000, 1, 0);
    wr_byte(8'($urandom), 0, "R6 standard after long reset");

    for (int r = 0; r < 6; r++) begin
      bit want = 1'($urandom_range(0, 1));
      if (want && !spd) enter_od();
      if (!want && spd) bus_reset(2000, 0, 0);
      if ($urandom_range(0, 1) == 1) rd_byte(8'($urandom));
      else wr_byte(8'($urandom), 0, "R2 random mixed byte");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule